// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous system bus and a byte-wide asynchronous static RAM of 131,072 locations. The system side presents one request at a time: a 17-bit address, a write flag and 8-bit write data, qualified by `req_valid` and accepted while `req_ready` is high. The controller turns each accepted request into the memory's pin sequence and reports completion with a one-cycle `rsp_valid` pulse. For reads, the pulse carries the data on `rsp_rdata`.

The memory is selected only when its active-low enable is LOW and its active-high enable is HIGH. Any other combination is standby, with the data pins high-impedance. With the memory selected, a LOW write enable stores data. With write enable HIGH, a LOW output enable makes the memory drive the data pins. With both HIGH, the data pins float (output-disable mode). The shared data bus is modelled as three separate buses: `mem_dq_out`, `mem_dq_oe` and `mem_dq_in`.

Three wait counts are parameters, each given in clock cycles and each at least 1:
- `RD_CYC`: the address-to-data access time for a read.
- `WR_CYC`: the width of the write-enable pulse.
- `TURN_CYC`: the time the memory needs to release the bus after a read.

All memory pins come straight from flops.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory is deselected: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A read accepted at clock edge E holds the following for exactly `RD_CYC` cycles after E: `mem_cs_n`=0, `mem_cs`=1, `mem_we_n`=1, `mem_oe_n`=0, with the request address on `mem_addr`. It then samples `mem_dq_in` at edge E+`RD_CYC`, and presents `rsp_valid`=1 with that value on `rsp_rdata` for the one cycle that follows.
- R3: A write accepted at edge E holds the following for exactly `WR_CYC` cycles: `mem_we_n`=0, `mem_oe_n`=1, the memory selected, `mem_dq_oe`=1 and the write data on `mem_dq_out`.
- R4: The write data stays driven, with the memory still selected, for one cycle after `mem_we_n` rises. In the cycle after that, the bus is released, the memory is deselected and `rsp_valid` pulses for one cycle.
- R5: The controller never drives the data bus while `mem_oe_n` is 0, and it drives the bus only while the memory is selected with `mem_oe_n`=1.
- R6: `mem_addr` is stable throughout every interval in which the memory is selected.
- R7: After a read, `req_ready` stays low for `TURN_CYC` cycles after `mem_oe_n` rises, so no new access can begin during that time.
- R8: `req_valid` is ignored while `req_ready` is low. A request that is withdrawn before the controller is idle causes no memory access.
- R9: `rsp_valid` is never high for two cycles in a row, and `rsp_rdata` changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle; a request is accepted on this edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 17 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
The bench goes after the following corner cases, each of which exposes a specific design fault:

- **Read sample point.** The bench counts the cycles with output enable low and checks the exact cycle in which `rsp_rdata` becomes valid. A controller that samples one cycle early, or that moves the address before sampling, returns stale or wrong data.
- **Read followed at once by a write.** The bench expects `req_ready` to stay low through the whole turnaround window. A design that skips the turnaround would drive the bus while the memory may still be releasing it.
- **End of a write.** The bench expects the data to stay driven for one cycle after write enable rises. A design that releases data and write enable together would fail the hold check.
- **Request during a busy cycle.** A request is raised while the controller is busy and then withdrawn. A controller that latched it anyway would corrupt a location, and the bench reads that location back to catch it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_WHOLD = 3'd3,
      ST_TURN  = 3'd4
   } ctl_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned cnt_bits(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_state_t        nxt_state,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe
);
   logic sel_d, we_d, oe_d, drv_d;

   always_comb begin
      sel_d = (nxt_state == ST_READ) || (nxt_state == ST_WRITE) || (nxt_state == ST_WHOLD);
      we_d  = (nxt_state == ST_WRITE);
      oe_d  = (nxt_state == ST_READ);
      drv_d = (nxt_state == ST_WRITE) || (nxt_state == ST_WHOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_cs_n  <= 1'b1;
         mem_cs    <= 1'b0;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_cs_n  <= !sel_d;
         mem_cs    <= sel_d;
         mem_we_n  <= !we_d;
         mem_oe_n  <= !oe_d;
         mem_dq_oe <= drv_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end
endmodule

// File: rtl/sram_rsp_capture.sv
module sram_rsp_capture #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_fire,
   input  logic              wr_fire,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_fire || wr_fire;
         if (rd_fire)
            rsp_rdata <= mem_dq_in;
      end
   end
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RD_CYC   = 2,
   parameter int unsigned WR_CYC   = 2,
   parameter int unsigned TURN_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_cs,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int unsigned MAX_CYC = max3(RD_CYC, WR_CYC, TURN_CYC);
   localparam int unsigned CNT_W   = cnt_bits(MAX_CYC);
   localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (RD_CYC < 1 || WR_CYC < 1 || TURN_CYC < 1) begin : g_bad_wait
         $error("every wait count must be at least 1");
      end
   endgenerate

   ctl_state_t       state_q, state_d;
   logic             accept;
   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             rd_fire, wr_fire;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      rd_fire  = 1'b0;
      wr_fire  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_d = ST_WRITE;
                  tmr_val = WR_LD;
               end else begin
                  state_d = ST_READ;
                  tmr_val = RD_LD;
               end
            end
         end
         ST_READ: begin
            if (tmr_done) begin
               rd_fire  = 1'b1;
               state_d  = ST_TURN;
               tmr_load = 1'b1;
               tmr_val  = TURN_LD;
            end
         end
         ST_WRITE: begin
            if (tmr_done)
               state_d = ST_WHOLD;
         end
         ST_WHOLD: begin
            wr_fire = 1'b1;
            state_d = ST_IDLE;
         end
         ST_TURN: begin
            if (tmr_done)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .nxt_state  (state_d),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_cs_n   (mem_cs_n),
      .mem_cs     (mem_cs),
      .mem_we_n   (mem_we_n),
      .mem_oe_n   (mem_oe_n),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe)
   );

   sram_rsp_capture #(.DATA_W(DATA_W)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_fire   (rd_fire),
      .wr_fire   (wr_fire),
      .mem_dq_in (mem_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              mem_cs_n,
   input logic              mem_cs,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_dq_oe
);
   assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $rose(mem_we_n)) |-> mem_dq_oe);

   assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_cs_n && mem_cs));

   assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> !req_ready);

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(rsp_rdata));
endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .mem_cs_n  (mem_cs_n),
   .mem_cs    (mem_cs),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_addr  (mem_addr),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_access_ctrl_bench.sv
`timescale 1ns/1ps
module sram_access_ctrl_bench;
   localparam int AW = 17;
   localparam int DW = 8;
   localparam int RD = 3;
   localparam int WR = 2;
   localparam int TN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_out;
   logic [DW-1:0] mem_dq_in;

   int n_chk = 0;
   int n_fail = 0;
   int n_wr_strobes = 0;

   always #4 clk = ~clk;

   sram_access_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_CYC(WR), .TURN_CYC(TN))
   u_sram_access_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory model
   logic [DW-1:0] mem [int];
   logic          mem_upd = 1'b0;

   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!mem_cs_n && mem_cs && !mem_we_n && mem_dq_oe) begin
         mem[int'(mem_addr)] = mem_dq_out;
         n_wr_strobes = n_wr_strobes + 1;
         mem_upd = ~mem_upd;
      end
   end

   always @(mem_cs_n or mem_cs or mem_we_n or mem_oe_n or mem_addr or mem_upd) begin
      if (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n)
         mem_dq_in = mem_rd(mem_addr);
      else
         mem_dq_in = 8'hEE;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req_ready == 1'b1, req, "ready", 32'(req_ready), 1);
      chk(mem_cs_n && !mem_cs, req, "deselect", {mem_cs_n, mem_cs}, 2'b10);
      chk(mem_we_n && mem_oe_n, req, "we/oe high", {mem_we_n, mem_oe_n}, 2'b11);
      chk(!mem_dq_oe, req, "bus released", 32'(mem_dq_oe), 0);
   endtask

   // starts and ends just after a negedge
   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < RD; k++) begin
         chk(!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n, "R2", "read pins",
             {mem_cs_n, mem_cs, mem_we_n, mem_oe_n}, 4'b0110);
         chk(mem_addr == a, "R2", "read addr", 32'(mem_addr), 32'(a));
         chk(!mem_dq_oe, "R5", "no drive in read", 32'(mem_dq_oe), 0);
         chk(!rsp_valid, "R2", "no early rsp", 32'(rsp_valid), 0);
         @(negedge clk);
      end
      chk(rsp_valid, "R2", "rsp pulse", 32'(rsp_valid), 1);
      chk(rsp_rdata == exp, "R2", "read data", 32'(rsp_rdata), 32'(exp));
      chk(mem_oe_n && mem_cs_n, "R2", "read ended", {mem_oe_n, mem_cs_n}, 2'b11);
      for (int k = 0; k < TN; k++) begin
         chk(!req_ready, "R7", "turnaround busy", 32'(req_ready), 0);
         if (k == 1) chk(!rsp_valid, "R9", "pulse one cycle", 32'(rsp_valid), 0);
         @(negedge clk);
      end
      chk(!rsp_valid, "R9", "pulse one cycle", 32'(rsp_valid), 0);
      chk_idle("R7");
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input bit poke_busy);
      logic [DW-1:0] held;
      held = rsp_rdata;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < WR; k++) begin
         if (poke_busy && k == 0) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 17'h1; req_wdata = ~d;
         end
         chk(!mem_cs_n && mem_cs && !mem_we_n && mem_oe_n, "R3", "write pins",
             {mem_cs_n, mem_cs, mem_we_n, mem_oe_n}, 4'b0101);
         chk(mem_dq_oe && mem_dq_out == d, "R3", "write data", {mem_dq_oe, mem_dq_out},
             {1'b1, d});
         chk(mem_addr == a, "R6", "write addr", 32'(mem_addr), 32'(a));
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(mem_we_n && mem_dq_oe && !mem_cs_n, "R4", "data hold",
          {mem_we_n, mem_dq_oe, mem_cs_n}, 3'b110);
      chk(mem_dq_out == d, "R4", "hold value", 32'(mem_dq_out), 32'(d));
      @(negedge clk);
      chk(rsp_valid, "R4", "write done pulse", 32'(rsp_valid), 1);
      chk(rsp_rdata == held, "R9", "rdata unchanged by write", 32'(rsp_rdata), 32'(held));
      chk_idle("R4");
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int strobes;
      repeat (3) @(negedge clk);
      chk_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");
      chk(!rsp_valid && rsp_rdata == 0, "R1", "rsp reset", {rsp_valid, rsp_rdata}, 0);

      // basic write then read back
      do_write(17'h00012, 8'h5A, 1'b0);
      do_read(17'h00012, 8'h5A);
      // top address, different pattern
      do_write(17'h1FFFF, 8'hC3, 1'b0);
      do_write(17'h00013, 8'h77, 1'b0);
      do_read(17'h1FFFF, 8'hC3);
      // read directly followed by write (turnaround inside do_read)
      do_write(17'h00000, 8'h81, 1'b0);
      do_read(17'h00013, 8'h77);
      do_write(17'h00013, 8'h3C, 1'b0);
      do_read(17'h00013, 8'h3C);

      // R8: request raised while busy, withdrawn before idle
      strobes = n_wr_strobes;
      do_write(17'h00012, 8'h99, 1'b1);
      chk(n_wr_strobes - strobes == WR, "R8", "only one write burst",
          32'(n_wr_strobes - strobes), WR);
      repeat (3) @(negedge clk);
      chk_idle("R8");
      do_read(17'h00013, 8'h3C);
      do_read(17'h00012, 8'h99);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule